// File: doc/BRIEF.md
# Iterative MD5 Block Hasher

The block computes the MD5 digest of one message block that has already been padded to 512 bits outside the core. A job begins when a start strobe is sampled while the core is idle. The block is captured, the working words are loaded with the standard initial chaining value, and one MD5 round runs per clock for 64 clocks. A final clock adds the working words to the initial value. The 128-bit digest appears together with a one-cycle done pulse.

Each job is a single block. The core keeps no chaining value between jobs, so every job restarts from the standard initial value. The latency is fixed, and several cores can be placed side by side, each fed by a shared padding stage.

Top module: `md5_block_core`

## Requirements
- R1: The block input is split into sixteen 32-bit message words. Word j is `block_in[511-32*j -: 32]`, so word 0 sits in the top bits.
- R2: Each accepted job loads the working words a, b, c, d with 0x67452301, 0xefcdab89, 0x98badcfe and 0x10325476.
- R3: The round function and the message-word index depend on the round number i, in four groups:
  - Rounds 0 to 15 use `(b&c)|(~b&d)` with index i.
  - Rounds 16 to 31 use `(d&b)|(~d&c)` with index (5i+1) mod 16.
  - Rounds 32 to 47 use `b^c^d` with index (3i+5) mod 16.
  - Rounds 48 to 63 use `c^(b|~d)` with index 7i mod 16.
- R4: Each round computes `b + rotl(a+F+K[i]+M[g], s)` as the new b and moves the other words along (a takes d, d takes c, c takes b). K[i] is floor(|sin(i+1)|·2^32). The rotate amounts cycle within each group of sixteen rounds as follows:
  - first group: 7, 12, 17, 22
  - second group: 5, 9, 14, 20
  - third group: 4, 11, 16, 23
  - fourth group: 6, 10, 15, 21
- R5: The digest is the initial value plus the final working words, word by word modulo 2^32. It is packed as {a, b, c, d}, with a in bits 127:96.
- R6: done is high for exactly one cycle, 65 clock edges after the edge that samples an accepted start.
- R7: After reset the digest is zero and done is low. The digest changes only on the cycle in which done rises and holds otherwise.
- R8: A start sampled while a job is running is ignored. The running job's result and timing are unchanged, and no extra done is produced.
- R9: A start sampled on the edge that follows the done cycle is accepted, so jobs can run back to back every 66 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Job strobe, honoured only when idle |
| block_in | input | 512 | Padded message block |
| digest | output | 128 | Result {a,b,c,d}, held between jobs |
| done | output | 1 | One-cycle pulse, digest valid |

## Verification
Every result is due exactly 65 edges after the edge that samples an accepted start.

The driver records that edge number for each job in the scoreboard queue, together with a digest computed by an independent reference model that builds its constants from the sine formula. The monitor samples at falling edges and checks that each done arrives on its due edge with the expected digest. It also checks that the digest does not move in any cycle without done.

A stray start during a job, and a job launched on the edge after done, are checked at the ports. A stray start must not shift the due edge or add a result. A job launched on the edge after done must meet the same 65-edge deadline.

// File: rtl/md5_block_core.sv
module md5_block_core (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [511:0] block_in,
  output logic [127:0] digest,
  output logic         done
);

  localparam logic [31:0] IV_A = 32'h67452301;
  localparam logic [31:0] IV_B = 32'hefcdab89;
  localparam logic [31:0] IV_C = 32'h98badcfe;
  localparam logic [31:0] IV_D = 32'h10325476;

  logic [511:0] msg;
  logic [31:0]  a, b, c, d;
  logic [6:0]   cnt;
  logic         busy;

  logic [1:0]  grp;
  logic [3:0]  idx, g;
  logic [4:0]  sh;
  logic [31:0] f, kc, mw, sum, rot;

  assign grp = cnt[5:4];
  assign idx = cnt[3:0];

  function automatic logic [31:0] kconst(input logic [5:0] r);
    case (r)
      6'd0:  return 32'hd76aa478; 6'd1:  return 32'he8c7b756;
      6'd2:  return 32'h242070db; 6'd3:  return 32'hc1bdceee;
      6'd4:  return 32'hf57c0faf; 6'd5:  return 32'h4787c62a;
      6'd6:  return 32'ha8304613; 6'd7:  return 32'hfd469501;
      6'd8:  return 32'h698098d8; 6'd9:  return 32'h8b44f7af;
      6'd10: return 32'hffff5bb1; 6'd11: return 32'h895cd7be;
      6'd12: return 32'h6b901122; 6'd13: return 32'hfd987193;
      6'd14: return 32'ha679438e; 6'd15: return 32'h49b40821;
      6'd16: return 32'hf61e2562; 6'd17: return 32'hc040b340;
      6'd18: return 32'h265e5a51; 6'd19: return 32'he9b6c7aa;
      6'd20: return 32'hd62f105d; 6'd21: return 32'h02441453;
      6'd22: return 32'hd8a1e681; 6'd23: return 32'he7d3fbc8;
      6'd24: return 32'h21e1cde6; 6'd25: return 32'hc33707d6;
      6'd26: return 32'hf4d50d87; 6'd27: return 32'h455a14ed;
      6'd28: return 32'ha9e3e905; 6'd29: return 32'hfcefa3f8;
      6'd30: return 32'h676f02d9; 6'd31: return 32'h8d2a4c8a;
      6'd32: return 32'hfffa3942; 6'd33: return 32'h8771f681;
      6'd34: return 32'h6d9d6122; 6'd35: return 32'hfde5380c;
      6'd36: return 32'ha4beea44; 6'd37: return 32'h4bdecfa9;
      6'd38: return 32'hf6bb4b60; 6'd39: return 32'hbebfbc70;
      6'd40: return 32'h289b7ec6; 6'd41: return 32'heaa127fa;
      6'd42: return 32'hd4ef3085; 6'd43: return 32'h04881d05;
      6'd44: return 32'hd9d4d039; 6'd45: return 32'he6db99e5;
      6'd46: return 32'h1fa27cf8; 6'd47: return 32'hc4ac5665;
      6'd48: return 32'hf4292244; 6'd49: return 32'h432aff97;
      6'd50: return 32'hab9423a7; 6'd51: return 32'hfc93a039;
      6'd52: return 32'h655b59c3; 6'd53: return 32'h8f0ccc92;
      6'd54: return 32'hffeff47d; 6'd55: return 32'h85845dd1;
      6'd56: return 32'h6fa87e4f; 6'd57: return 32'hfe2ce6e0;
      6'd58: return 32'ha3014314; 6'd59: return 32'h4e0811a1;
      6'd60: return 32'hf7537e82; 6'd61: return 32'hbd3af235;
      6'd62: return 32'h2ad7d2bb; default: return 32'heb86d391;
    endcase
  endfunction

  always_comb begin
    case (grp)
      2'd0: begin
        f = (b & c) | (~b & d);
        g = idx;
        case (idx[1:0]) 2'd0: sh = 5'd7; 2'd1: sh = 5'd12; 2'd2: sh = 5'd17; default: sh = 5'd22; endcase
      end
      2'd1: begin
        f = (d & b) | (~d & c);
        g = 4'((idx << 2) + idx + 4'd1);
        case (idx[1:0]) 2'd0: sh = 5'd5; 2'd1: sh = 5'd9; 2'd2: sh = 5'd14; default: sh = 5'd20; endcase
      end
      2'd2: begin
        f = b ^ c ^ d;
        g = 4'((idx << 1) + idx + 4'd5);
        case (idx[1:0]) 2'd0: sh = 5'd4; 2'd1: sh = 5'd11; 2'd2: sh = 5'd16; default: sh = 5'd23; endcase
      end
      default: begin
        f = c ^ (b | ~d);
        g = 4'((idx << 3) - idx);
        case (idx[1:0]) 2'd0: sh = 5'd6; 2'd1: sh = 5'd10; 2'd2: sh = 5'd15; default: sh = 5'd21; endcase
      end
    endcase
  end

  assign kc  = kconst(cnt[5:0]);
  assign mw  = msg[(5'd15 - {1'b0, g}) * 32 +: 32];
  assign sum = a + f + kc + mw;
  assign rot = (sum << sh) | (sum >> (6'd32 - {1'b0, sh}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg <= '0; a <= '0; b <= '0; c <= '0; d <= '0;
      cnt <= '0; busy <= 1'b0; digest <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          msg <= block_in;
          a <= IV_A; b <= IV_B; c <= IV_C; d <= IV_D;
          cnt <= '0;
          busy <= 1'b1;
        end
      end else if (cnt[6]) begin
        digest <= {IV_A + a, IV_B + b, IV_C + c, IV_D + d};
        done <= 1'b1;
        busy <= 1'b0;
      end else begin
        a <= d;
        d <= c;
        c <= b;
        b <= b + rot;
        cnt <= cnt + 7'd1;
      end
    end
  end

  AST_LOAD_IV: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (a == IV_A && b == IV_B && c == IV_C && d == IV_D && cnt == 7'd0)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DIGEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(digest)); // R7
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cnt[6]) |=> (busy && cnt == $past(cnt) + 7'd1)); // R8
  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && !busy)); // R6

endmodule

// File: tb/md5_block_core_test.sv
module md5_block_core_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [511:0] block_in = '0;
  logic [127:0] digest;
  logic         done;

  always #4 clk = ~clk;

  md5_block_core uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .block_in(block_in), .digest(digest), .done(done)
  );

  typedef struct {
    logic [127:0] exp;
    int           due;
    string        tag;
  } item_t;

  item_t        sb[$];
  int           cyc = 0;
  int           nchk = 0;
  int           nfail = 0;
  logic [127:0] held = '0;
  logic         mon_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [127:0] ref_md5(input logic [511:0] blk);
    logic [31:0] w [16];
    logic [31:0] va, vb, vc, vd, fx, tmp, kk;
    int gi, sa;
    int rot_tab [4][4];
    real sv;
    rot_tab = '{'{7, 12, 17, 22}, '{5, 9, 14, 20}, '{4, 11, 16, 23}, '{6, 10, 15, 21}};
    for (int j = 0; j < 16; j++) w[j] = blk[511 - 32*j -: 32];
    va = 32'h67452301; vb = 32'hefcdab89; vc = 32'h98badcfe; vd = 32'h10325476;
    for (int i = 0; i < 64; i++) begin
      if (i < 16)      begin fx = (vb & vc) | (~vb & vd); gi = i; end
      else if (i < 32) begin fx = (vd & vb) | (~vd & vc); gi = (5*i + 1) % 16; end
      else if (i < 48) begin fx = vb ^ vc ^ vd;           gi = (3*i + 5) % 16; end
      else             begin fx = vc ^ (vb | ~vd);        gi = (7*i) % 16; end
      sv = $sin(real'(i + 1));
      if (sv < 0.0) sv = -sv;
      kk = 32'(longint'($floor(sv * 4294967296.0)));
      sa = rot_tab[i/16][i%4];
      tmp = vd; vd = vc; vc = vb;
      vb = vb + rotl(va + fx + kk + w[gi], sa);
      va = tmp;
    end
    return {va + 32'h67452301, vb + 32'hefcdab89, vc + 32'h98badcfe, vd + 32'h10325476};
  endfunction

  task automatic fail(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nfail++;
    $display("FAIL %s actual=%032h expected=%032h", tag, act, exp);
  endtask

  // Drive start at a falling edge; the next rising edge samples it.
  task automatic launch(input logic [511:0] blk, input string tag, input logic [127:0] exp_in, input bit use_exp);
    item_t it;
    block_in = blk;
    start = 1'b1;
    it.exp = use_exp ? exp_in : ref_md5(blk);
    it.due = cyc + 1 + 65;
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (sb.size() != 0) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (done) begin
        nchk++;
        if (sb.size() == 0) begin
          fail("R8 unexpected done", digest, held);
        end else begin
          item_t it;
          it = sb.pop_front();
          if (digest !== it.exp) fail(it.tag, digest, it.exp);
          nchk++;
          if (cyc != it.due) fail({"R6 latency ", it.tag}, 128'(cyc), 128'(it.due));
        end
        held = digest;
      end else begin
        nchk++;
        if (digest !== held) fail("R7 digest hold", digest, held);
      end
    end
  end

  initial begin
    logic [511:0] blk;
    repeat (3) @(negedge clk);
    nchk++;
    if (digest !== '0 || done !== 1'b0) fail("R7 reset state", {digest[126:0], done}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;

    // R1 R5: empty message, padded (first byte 0x80 in word 0)
    blk = '0; blk[511 -: 32] = 32'h00000080;
    launch(blk, "R1 R5 empty-msg", {32'hd98c1dd4, 32'h04b2008f, 32'h980980e9, 32'h7e42f8ec}, 1'b1);
    wait_idle();
    // R3 R4: three-byte message, length 24 bits in word 14
    blk = '0; blk[511 -: 32] = 32'h80636261; blk[511 - 32*14 -: 32] = 32'd24;
    launch(blk, "R3 R4 abc-msg", {32'h98500190, 32'hb04fd23c, 32'h7d3f96d6, 32'h727fe128}, 1'b1);
    wait_idle();
    launch('0, "R2 all-zero block", '0, 1'b0);
    wait_idle();
    launch({512{1'b1}}, "R3 all-one block", '0, 1'b0);
    wait_idle();
    for (int j = 0; j < 16; j++) blk[511 - 32*j -: 32] = 32'(j) * 32'h01010101;
    launch(blk, "R1 ramp words", '0, 1'b0);
    wait_idle();

    // R8: stray starts while busy
    for (int j = 0; j < 16; j++) blk[511 - 32*j -: 32] = $urandom;
    launch(blk, "R8 job with stray start", '0, 1'b0);
    repeat (20) @(negedge clk);
    block_in = {512{1'b1}}; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_idle();
    repeat (80) @(negedge clk);

    // R9: back-to-back jobs launched in the done cycle
    for (int n = 0; n < 6; n++) begin
      for (int j = 0; j < 16; j++) blk[511 - 32*j -: 32] = $urandom;
      if (n == 0) launch(blk, "R9 b2b first", '0, 1'b0);
      else begin
        while (!done) @(negedge clk);
        launch(blk, "R9 back-to-back", '0, 1'b0);
      end
    end
    wait_idle();

    for (int n = 0; n < 4; n++) begin
      for (int j = 0; j < 16; j++) blk[511 - 32*j -: 32] = $urandom;
      launch(blk, "R4 random block", '0, 1'b0);
      wait_idle();
    end
    repeat (10) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule